// File: doc/BRIEF.md
# Automatic Sign-Bit Field Selector

This block watches a stream of 32-bit signed results and works out how much sign-bit headroom each one leaves at its top. Four 20-bit windows of the result are possible, spaced four bits apart. Code 0 is the window at the most significant end and code 3 is the window at the least significant end. For each valid result the block finds the least significant window that still holds the value with at least one sign bit. It keeps a running maximum of that requirement. The held window can only move toward more significant windows.

A program strobe marks any register update. It clears the held choice back to the least significant window. The choice then stays frozen until ten line-sync pulses have passed, so that the upstream accumulator pipeline can flush. An indicator output always shows the held automatic choice. A second output feeds the gain stage: when automatic mode is enabled it carries the automatic code, and otherwise it carries a manually programmed code.

Top module: `sign_field_picker`

## Requirements
- R1: After reset, the held code is 3 (least significant window). `ind_o` reads 3, and `field_o` reads 3 when `auto_en_i` is high.
- R2: The need code for a result is found from its top bits, where bit 31 is the most significant:
  - if bits 31..27 are not all equal, the code is 0;
  - else if bits 31..23 are not all equal, the code is 1;
  - else if bits 31..19 are not all equal, the code is 2;
  - otherwise the code is 3.
- R3: A sampled result whose need code is numerically larger than the held code leaves the held code unchanged.
- R4: A sampled result whose need code is numerically smaller than the held code moves the held code to that need code. `ind_o` shows the new value one clock after the sample.
- R5: A high `prog_i` sets the held code to 3 and restarts the hold-off period, one clock later. This takes priority over any sample in the same cycle.
- R6: During hold-off, results are ignored and the held code stays at 3. Hold-off ends once ten falling edges of `line_i` have been seen after reset or after the last `prog_i`. A falling edge is `line_i` low on a clock edge where it was high on the previous clock edge. Nine falling edges are not enough.
- R7: A result presented while `valid_i` is low has no effect on the held code.
- R8: `field_o` equals the held code when `auto_en_i` is 1, and equals `man_code_i` when `auto_en_i` is 0. `ind_o` shows the held code in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_i | input | 1 | Register-program strobe; clears the choice |
| line_i | input | 1 | Line-sync pulse; its falling edge is counted |
| valid_i | input | 1 | Result qualifier |
| result_i | input | 32 | Signed result to examine |
| auto_en_i | input | 1 | 1 selects the automatic code for `field_o` |
| man_code_i | input | 2 | Manually programmed window code |
| field_o | output | 2 | Window code sent to the gain stage |
| ind_o | output | 2 | Held automatic window code, always valid |

## Verification
On every cycle, the assertions check the following:
- the held code never moves toward a less significant window except on a program strobe;
- a strobe returns the held code to 3 with a full hold-off count;
- the code stays at 3 throughout hold-off;
- a cycle with `valid_i` low or with no falling edge leaves the relevant state unchanged.

Only the bench scenarios can show the remaining behaviour:
- that each bit pattern maps to the right code;
- that the tenth falling edge, and not the ninth, opens sampling;
- that the manual/automatic multiplexing of the gain-stage code is correct.

// File: rtl/sign_field_picker.sv
module sign_field_picker #(
  parameter int DW         = 32,
  parameter int HOLD_LINES = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_i,
  input  logic          line_i,
  input  logic          valid_i,
  input  logic [DW-1:0] result_i,
  input  logic          auto_en_i,
  input  logic [1:0]    man_code_i,
  output logic [1:0]    field_o,
  output logic [1:0]    ind_o
);
  localparam int CW = $clog2(HOLD_LINES + 1);
  localparam logic [CW-1:0] HOLD_INIT = CW'(HOLD_LINES);

  logic [1:0]    held;
  logic [1:0]    need;
  logic [CW-1:0] wait_cnt;
  logic          line_q;
  logic          line_fall;
  logic          sample;

  wire top5_same  = (result_i[DW-1 -: 5]  == {5{result_i[DW-1]}});
  wire top9_same  = (result_i[DW-1 -: 9]  == {9{result_i[DW-1]}});
  wire top13_same = (result_i[DW-1 -: 13] == {13{result_i[DW-1]}});

  always_comb begin
    if (!top5_same)       need = 2'd0;
    else if (!top9_same)  need = 2'd1;
    else if (!top13_same) need = 2'd2;
    else                  need = 2'd3;
  end

  assign line_fall = line_q & ~line_i;
  assign sample    = valid_i && (wait_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_cnt <= HOLD_INIT;
      held     <= 2'd3;
    end else if (prog_i) begin
      wait_cnt <= HOLD_INIT;
      held     <= 2'd3;
    end else begin
      if (line_fall && wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
      if (sample && need < held)       held     <= need;
    end
  end

  assign ind_o   = held;
  assign field_o = auto_en_i ? held : man_code_i;

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_i |=> held <= $past(held));

  a_r5_prog_clear: assert property (@(posedge clk) disable iff (!rst_n)
    prog_i |=> (held == 2'd3) && (wait_cnt == HOLD_INIT));

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_cnt != '0) |-> held == 2'd3);

  a_r6_count_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_i && !line_fall) |=> $stable(wait_cnt));

  a_r7_invalid_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_i && !valid_i) |=> $stable(held));
endmodule

// File: tb/sign_field_picker_test.sv
module sign_field_picker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_i = 1'b0;
  logic        line_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] result_i = '0;
  logic        auto_en_i = 1'b1;
  logic [1:0]  man_code_i = 2'd0;
  logic [1:0]  field_o;
  logic [1:0]  ind_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sign_field_picker uut (.*);

  always #10 clk = ~clk;

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic line_pulse();
    @(negedge clk) line_i = 1'b1;
    @(negedge clk) line_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic program_strobe();
    @(negedge clk) prog_i = 1'b1;
    @(negedge clk) prog_i = 1'b0;
  endtask

  task automatic arm();
    program_strobe();
    for (int i = 0; i < 10; i++) line_pulse();
  endtask

  task automatic feed(logic [31:0] v, logic vld);
    @(negedge clk) begin result_i = v; valid_i = vld; end
    @(negedge clk) begin valid_i = 1'b0; result_i = '0; end
  endtask

  task automatic t_reset();
    check("R1 ind", ind_o, 2'd3);
    check("R1 field", field_o, 2'd3);
  endtask

  task automatic t_mapping();
    arm(); feed(32'h0800_0000, 1'b1); check("R2 pos code0", ind_o, 2'd0);
    arm(); feed(32'h8000_0000, 1'b1); check("R2 neg code0", ind_o, 2'd0);
    arm(); feed(32'h0100_0000, 1'b1); check("R2 pos code1", ind_o, 2'd1);
    arm(); feed(32'hFF7F_FFFF, 1'b1); check("R2 neg code1", ind_o, 2'd1);
    arm(); feed(32'h0040_0000, 1'b1); check("R2 pos code2", ind_o, 2'd2);
    arm(); feed(32'h0004_0000, 1'b1); check("R2 pos code3", ind_o, 2'd3);
    arm(); feed(32'hFFF8_0000, 1'b1); check("R2 neg code3", ind_o, 2'd3);
  endtask

  task automatic t_sticky();
    arm();
    feed(32'h0040_0000, 1'b1); check("R4 to code2", ind_o, 2'd2);
    feed(32'h0000_0001, 1'b1); check("R3 hold code2", ind_o, 2'd2);
    feed(32'hFF00_0000, 1'b1); check("R4 to code1", ind_o, 2'd1);
    feed(32'h0040_0000, 1'b1); check("R3 hold code1", ind_o, 2'd1);
  endtask

  task automatic t_invalid();
    feed(32'h7FFF_FFFF, 1'b0); check("R7 invalid ignored", ind_o, 2'd1);
  endtask

  task automatic t_prog();
    program_strobe(); check("R5 cleared", ind_o, 2'd3);
    @(negedge clk) begin prog_i = 1'b1; valid_i = 1'b1; result_i = 32'h8000_0000; end
    @(negedge clk) begin prog_i = 1'b0; valid_i = 1'b0; end
    check("R5 priority over sample", ind_o, 2'd3);
  endtask

  task automatic t_holdoff();
    program_strobe();
    for (int i = 0; i < 9; i++) line_pulse();
    feed(32'h8000_0000, 1'b1); check("R6 nine edges frozen", ind_o, 2'd3);
    @(negedge clk) line_i = 1'b1;
    repeat (5) @(negedge clk);
    feed(32'h8000_0000, 1'b1); check("R6 high level not counted", ind_o, 2'd3);
    @(negedge clk) line_i = 1'b0;
    @(negedge clk);
    feed(32'h8000_0000, 1'b1); check("R6 tenth edge opens", ind_o, 2'd0);
  endtask

  task automatic t_mux();
    arm(); feed(32'h0100_0000, 1'b1);
    @(negedge clk) begin auto_en_i = 1'b0; man_code_i = 2'd2; end
    #1;
    check("R8 manual field", field_o, 2'd2);
    check("R8 indicator in manual", ind_o, 2'd1);
    @(negedge clk) man_code_i = 2'd3;
    #1 check("R8 manual field 3", field_o, 2'd3);
    @(negedge clk) auto_en_i = 1'b1;
    #1 check("R8 auto field", field_o, 2'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_sticky();
    t_invalid();
    t_prog();
    t_holdoff();
    t_mux();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule